// File: doc/BRIEF.md
# Streaming Video Trace Monitor

This block is a passive tap for a valid/ready video stream. It watches the stream's handshake, packet markers and the low bits of the data bus, and it never drives any of them. For every packet it counts three kinds of cycles: cycles that move a beat, cycles where the source offers nothing, and cycles where the sink holds the source off. It also records how many clocks separate this packet's start from the previous packet's start, and it classifies the packet as video, control or other.

When a packet ends, the monitor turns these figures into one summary record. It sends the record as a short burst of words on a narrow trace port that has its own valid/ready handshake and its own first-word and last-word markers. Pixel values are never reported. This keeps the trace traffic down to a few words per packet, so a debug collector can watch many streams at once.

The record stays held until the trace port accepts it. Only one record can be pending at a time. A record that completes while the port is still busy is discarded, and the next record that does go out carries a flag to say so.

Top module: `vid_trace_mon`

## Requirements
- R1: A packet window opens on a transfer cycle (valid and ready both high) that has the start marker, and closes on a transfer cycle that has the end marker. A single beat may carry both markers. Transfers while no window is open, and end markers while no window is open, produce no record.
- R2: The record's beat count is the number of transfer cycles in the window, counting the opening beat and the closing beat.
- R3: The record's idle count is the number of cycles strictly inside the window where valid is low.
- R4: The record's backpressure count is the number of cycles strictly inside the window where valid is high and ready is low.
- R5: The beat, idle and backpressure counts stop at 2^CNT_W-1, and the interval stops at 2^IVL_W-1. None of them wraps.
- R6: The interval is the number of clocks from the previous packet's opening transfer to this packet's opening transfer. For the first packet after reset, it is the number of clocks from the first edge after reset.
- R7: The type code comes from the low nibble of the opening beat's data: 0x0 gives code 0 (video), 0xF gives code 1 (control), and any other value gives code 2.
- R8: The record is packed LSB first as follows: an 8-bit header (bits 1:0 type code, bit 2 dropped flag, bits 7:3 zero), then the beat count, the idle count, the backpressure count and the interval. It is zero padded to a whole number of TRACE_W words and sent least significant word first. The first word is marked start and the last word is marked end.
- R9: While a trace word is valid and not accepted, the word and its markers stay unchanged. If the trace port is free, or its last word is accepted in the same cycle, the record's first word is valid on the cycle after the closing transfer.
- R10: A record that completes while the trace port is not free is discarded. The next record that is loaded carries a dropped flag of 1, and the flag is then cleared.
- R11: After reset no trace word is valid, no window is open and no drop is pending.
- R12: A start-marked transfer inside an open window abandons the old window and starts a new packet. The abandoned packet produces no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_data_lo | input | NIB_W | Low bits of the observed stream data |
| mon_valid | input | 1 | Observed source valid |
| mon_ready | input | 1 | Observed sink ready |
| mon_sop | input | 1 | Observed start-of-packet marker |
| mon_eop | input | 1 | Observed end-of-packet marker |
| trc_data | output | TRACE_W | Trace record word |
| trc_valid | output | 1 | Trace word valid |
| trc_ready | input | 1 | Trace collector ready |
| trc_sop | output | 1 | First word of a record |
| trc_eop | output | 1 | Last word of a record |

## Verification
A stuck or stale window flag shows up at the next packet boundary. The monitor then either emits a record for traffic it should ignore, or attaches the stall cycles of the gap to the wrong packet, and either mistake is visible in the next record's counts. A wrong word index or shift state corrupts the field layout, or misplaces the start and end markers, within the one record that is being drained. A drop flag that sticks or clears at the wrong time changes header bit 2 of the very next record. The bench compares every field of every record against an arithmetic model. It sweeps packet length, stall mix, type nibble and trace-port readiness, and also drives saturation, restart and overflow patterns.

// File: rtl/vtm_pkg.sv
package vtm_pkg;

  localparam int HDR_W = 8;
  localparam int HDR_DROP_BIT = 2;

  typedef enum logic [1:0] {
    KIND_VIDEO = 2'd0,
    KIND_CTRL  = 2'd1,
    KIND_OTHER = 2'd2
  } pkt_kind_e;

  function automatic pkt_kind_e classify(input logic [3:0] nib);
    if (nib == 4'h0)      return KIND_VIDEO;
    else if (nib == 4'hF) return KIND_CTRL;
    else                  return KIND_OTHER;
  endfunction

endpackage

// File: rtl/vtm_sat_ctr.sv
module vtm_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_comb begin
    if (load)                    nxt = load_val;
    else if (inc && cnt_q != TOP) nxt = cnt_q + 1'b1;
    else                         nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt;
  end
endmodule

// File: rtl/vtm_pkt_stats.sv
module vtm_pkt_stats
  import vtm_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int CNT_W = 16,
  parameter int IVL_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIB_W-1:0] mon_data_lo,
  input  logic             mon_valid,
  input  logic             mon_ready,
  input  logic             mon_sop,
  input  logic             mon_eop,
  output logic             rec_fire,
  output pkt_kind_e        rec_kind,
  output logic [CNT_W-1:0] rec_beats,
  output logic [CNT_W-1:0] rec_idle,
  output logic [CNT_W-1:0] rec_bp,
  output logic [IVL_W-1:0] rec_ivl
);
  localparam int NCTR = 3;
  localparam logic [IVL_W-1:0] IVL_TOP = '1;

  logic      in_pkt_q;
  pkt_kind_e kind_q;
  logic [IVL_W-1:0] ivl_q, ivl_cap_q;

  logic xfer, open_x, close_x;
  assign xfer    = mon_valid & mon_ready;
  assign open_x  = xfer & mon_sop;
  assign close_x = xfer & mon_eop & (mon_sop | in_pkt_q);

  // index 0: beats, 1: source idle, 2: sink backpressure
  logic [NCTR-1:0]  ctr_inc;
  logic [CNT_W-1:0] ctr_nxt [NCTR];

  assign ctr_inc[0] = in_pkt_q & xfer;
  assign ctr_inc[1] = in_pkt_q & ~mon_valid;
  assign ctr_inc[2] = in_pkt_q & mon_valid & ~mon_ready;

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    vtm_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (open_x),
      .load_val ((g == 0) ? CNT_W'(1) : CNT_W'(0)),
      .inc      (ctr_inc[g]),
      .nxt      (ctr_nxt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q  <= 1'b0;
      kind_q    <= KIND_VIDEO;
      ivl_q     <= '0;
      ivl_cap_q <= '0;
    end else begin
      if (close_x)     in_pkt_q <= 1'b0;
      else if (open_x) in_pkt_q <= 1'b1;

      if (open_x) begin
        kind_q    <= classify(mon_data_lo[3:0]);
        ivl_cap_q <= ivl_q;
        ivl_q     <= IVL_W'(1);
      end else if (ivl_q != IVL_TOP) begin
        ivl_q <= ivl_q + 1'b1;
      end
    end
  end

  assign rec_fire  = close_x;
  assign rec_kind  = open_x ? classify(mon_data_lo[3:0]) : kind_q;
  assign rec_ivl   = open_x ? ivl_q : ivl_cap_q;
  assign rec_beats = ctr_nxt[0];
  assign rec_idle  = ctr_nxt[1];
  assign rec_bp    = ctr_nxt[2];
endmodule

// File: rtl/vtm_rec_ser.sv
module vtm_rec_ser #(
  parameter int REC_W    = 64,
  parameter int TRACE_W  = 16,
  parameter int DROP_BIT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rec_fire,
  input  logic [REC_W-1:0]   rec_in,
  output logic [TRACE_W-1:0] trc_data,
  output logic               trc_valid,
  input  logic               trc_ready,
  output logic               trc_sop,
  output logic               trc_eop
);
  localparam int NWORDS = (REC_W + TRACE_W - 1) / TRACE_W;
  localparam int PAD_W  = NWORDS * TRACE_W;
  localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [PAD_W-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic vld_q, drop_q;
  logic free, load;
  logic [PAD_W-1:0] rec_pad;

  assign free    = ~vld_q | (trc_ready & (idx_q == LAST));
  assign load    = rec_fire & free;
  assign rec_pad = PAD_W'(rec_in) | (PAD_W'(drop_q) << DROP_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (load) begin
        sh_q  <= rec_pad;
        idx_q <= '0;
        vld_q <= 1'b1;
      end else if (vld_q && trc_ready) begin
        if (idx_q == LAST) begin
          vld_q <= 1'b0;
        end else begin
          sh_q  <= sh_q >> TRACE_W;
          idx_q <= idx_q + 1'b1;
        end
      end

      if (load)          drop_q <= 1'b0;
      else if (rec_fire) drop_q <= 1'b1;
    end
  end

  assign trc_data  = sh_q[TRACE_W-1:0];
  assign trc_valid = vld_q;
  assign trc_sop   = vld_q & (idx_q == '0);
  assign trc_eop   = vld_q & (idx_q == LAST);
endmodule

// File: rtl/vid_trace_mon.sv
module vid_trace_mon
  import vtm_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int CNT_W   = 16,
  parameter int IVL_W   = 24,
  parameter int TRACE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NIB_W-1:0]   mon_data_lo,
  input  logic               mon_valid,
  input  logic               mon_ready,
  input  logic               mon_sop,
  input  logic               mon_eop,
  output logic [TRACE_W-1:0] trc_data,
  output logic               trc_valid,
  input  logic               trc_ready,
  output logic               trc_sop,
  output logic               trc_eop
);
  localparam int REC_W = HDR_W + 3 * CNT_W + IVL_W;

  logic             rec_fire;
  pkt_kind_e        rec_kind;
  logic [CNT_W-1:0] rec_beats, rec_idle, rec_bp;
  logic [IVL_W-1:0] rec_ivl;
  logic [REC_W-1:0] rec_word;

  vtm_pkt_stats #(
    .NIB_W (NIB_W),
    .CNT_W (CNT_W),
    .IVL_W (IVL_W)
  ) u_stats (
    .clk         (clk),
    .rst         (rst),
    .mon_data_lo (mon_data_lo),
    .mon_valid   (mon_valid),
    .mon_ready   (mon_ready),
    .mon_sop     (mon_sop),
    .mon_eop     (mon_eop),
    .rec_fire    (rec_fire),
    .rec_kind    (rec_kind),
    .rec_beats   (rec_beats),
    .rec_idle    (rec_idle),
    .rec_bp      (rec_bp),
    .rec_ivl     (rec_ivl)
  );

  // drop flag (header bit 2) is merged in by the serializer
  assign rec_word = {rec_ivl, rec_bp, rec_idle, rec_beats,
                     (HDR_W - 2)'(0), rec_kind};

  vtm_rec_ser #(
    .REC_W    (REC_W),
    .TRACE_W  (TRACE_W),
    .DROP_BIT (HDR_DROP_BIT)
  ) u_ser (
    .clk       (clk),
    .rst       (rst),
    .rec_fire  (rec_fire),
    .rec_in    (rec_word),
    .trc_data  (trc_data),
    .trc_valid (trc_valid),
    .trc_ready (trc_ready),
    .trc_sop   (trc_sop),
    .trc_eop   (trc_eop)
  );
endmodule

// File: rtl/vid_trace_mon_chk.sv
module vid_trace_mon_chk #(
  parameter int TRACE_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               mon_valid,
  input logic               mon_ready,
  input logic               mon_sop,
  input logic               mon_eop,
  input logic [TRACE_W-1:0] trc_data,
  input logic               trc_valid,
  input logic               trc_ready,
  input logic               trc_sop,
  input logic               trc_eop
);
  // R11: reset leaves the trace port empty
  a_r11_idle_after_reset: assert property (@(posedge clk)
    rst |=> !trc_valid);

  // R9: an unaccepted word is held unchanged
  a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
    (trc_valid && !trc_ready) |=>
      (trc_valid && $stable(trc_data) && $stable(trc_sop) && $stable(trc_eop)));

  // R9: a one-beat packet on an idle port yields a first word next cycle
  a_r9_single_beat_latency: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && mon_ready && mon_sop && mon_eop && !trc_valid) |=>
      (trc_valid && trc_sop));

  // R8: after a last word, any following word opens a new record
  a_r8_next_record_opens: assert property (@(posedge clk) disable iff (rst)
    (trc_valid && trc_ready && trc_eop) |=> (!trc_valid || trc_sop));

  // R8: a record continues after an accepted non-final word
  a_r8_record_continues: assert property (@(posedge clk) disable iff (rst)
    (trc_valid && trc_ready && !trc_eop) |=> (trc_valid && !trc_sop));

  // R8: markers only accompany a valid word
  a_r8_markers_qualified: assert property (@(posedge clk) disable iff (rst)
    (trc_sop || trc_eop) |-> trc_valid);
endmodule

bind vid_trace_mon vid_trace_mon_chk #(.TRACE_W(TRACE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mon_valid (mon_valid),
  .mon_ready (mon_ready),
  .mon_sop   (mon_sop),
  .mon_eop   (mon_eop),
  .trc_data  (trc_data),
  .trc_valid (trc_valid),
  .trc_ready (trc_ready),
  .trc_sop   (trc_sop),
  .trc_eop   (trc_eop)
);

// File: tb/tb_vid_trace_mon.sv
`timescale 1ns/1ps
module tb_vid_trace_mon;
  localparam int NIB_W = 4, CNT_W = 4, IVL_W = 6, TRACE_W = 8;
  localparam int REC_W = 8 + 3*CNT_W + IVL_W;       // 26
  localparam int NW    = (REC_W + TRACE_W - 1) / TRACE_W; // 4
  localparam int CMAX  = (1 << CNT_W) - 1;
  localparam int IMAX  = (1 << IVL_W) - 1;

  logic clk = 0, rst = 1;
  logic [15:0] sdata = 0;
  logic sval = 0, srdy = 0, ssop = 0, seop = 0;
  logic [TRACE_W-1:0] trc_data;
  logic trc_valid, trc_ready, trc_sop, trc_eop;
  int rdy_mode = 0;

  always #2 clk = ~clk; // 250 MHz

  vid_trace_mon #(.NIB_W(NIB_W), .CNT_W(CNT_W), .IVL_W(IVL_W), .TRACE_W(TRACE_W)) dut (
    .clk(clk), .rst(rst), .mon_data_lo(sdata[3:0]), .mon_valid(sval), .mon_ready(srdy),
    .mon_sop(ssop), .mon_eop(seop), .trc_data(trc_data), .trc_valid(trc_valid),
    .trc_ready(trc_ready), .trc_sop(trc_sop), .trc_eop(trc_eop));

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int smin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // trace ready pattern
  int rcyc = 0;
  initial begin
    trc_ready = 1;
    forever begin
      @(posedge clk); #1;
      rcyc++;
      case (rdy_mode)
        0: trc_ready = 1;
        1: trc_ready = rcyc[0];
        2: trc_ready = 0;
        default: trc_ready = (rcyc % 3) != 0;
      endcase
    end
  end

  // arithmetic model + output checking, evaluated at negedge for the coming edge
  logic [31:0] expq [0:255];
  int wr = 0, rd = 0;
  int since = 0, m_beats = 0, m_idle = 0, m_bp = 0, m_kind = 0;
  bit m_in = 0, m_drop = 0, lat_pend = 0, pv = 0, pr = 0;
  logic [TRACE_W-1:0] pd; bit ps = 0, pe = 0;
  logic [31:0] rx = 0; int wi = 0;

  always @(negedge clk) begin
    // R9 latency of first word
    if (lat_pend) begin
      chk(trc_valid && trc_sop, "R9 first word latency", trc_valid, 1);
      lat_pend = 0;
    end
    // R9 hold under trace backpressure
    if (!rst && pv && !pr)
      chk(trc_valid && trc_data == pd && trc_sop == ps && trc_eop == pe,
          "R9 hold", trc_data, pd);
    pv = trc_valid; pr = trc_ready; pd = trc_data; ps = trc_sop; pe = trc_eop;

    if (rst) begin
      since = 0; m_in = 0; m_drop = 0; wi = 0;
    end else begin
      // receive
      if (trc_valid && trc_ready) begin
        if (trc_sop) begin
          if (wi != 0) chk(0, "R8 start marker position", wi, 0);
          wi = 0; rx = 0;
        end
        rx[wi*TRACE_W +: TRACE_W] = trc_data;
        wi++;
        if (trc_eop) begin
          chk(wi == NW, "R8 words per record", wi, NW);
          if (rd == wr) chk(0, "R1 unexpected record", 1, 0);
          else begin
            logic [31:0] e;
            e = expq[rd[7:0]]; rd++;
            chk(rx[1:0] == e[1:0], "R7 type code", rx[1:0], e[1:0]);
            chk(rx[2] == e[2], "R10 drop flag", rx[2], e[2]);
            chk(rx[7:3] == 0 && rx[31:26] == 0, "R8 zero bits", rx, 0);
            chk(rx[11:8] == e[11:8], "R2 beats", rx[11:8], e[11:8]);
            chk(rx[15:12] == e[15:12], "R3 idle", rx[15:12], e[15:12]);
            chk(rx[19:16] == e[19:16], "R4 backpressure", rx[19:16], e[19:16]);
            chk(rx[25:20] == e[25:20], "R6 interval", rx[25:20], e[25:20]);
          end
          wi = 0;
        end
      end
      // model the stream at the coming edge
      if (sval && srdy && ssop) begin
        int ivl;
        ivl = smin(since, IMAX); since = 1;
        m_in = 1; m_beats = 1; m_idle = 0; m_bp = 0;
        m_kind = (sdata[3:0] == 4'h0) ? 0 : (sdata[3:0] == 4'hF) ? 1 : 2;
        m_idle = ivl; // temporarily hold interval
        m_bp = 0;
        begin
          int keep_ivl; keep_ivl = m_idle; m_idle = 0;
          since = 1;
          m_ivl_store = keep_ivl;
        end
        if (seop) emit();
      end else begin
        since++;
        if (m_in) begin
          if (!sval) m_idle = smin(m_idle + 1, CMAX);
          else if (!srdy) m_bp = smin(m_bp + 1, CMAX);
          else begin
            m_beats = smin(m_beats + 1, CMAX);
            if (seop) emit();
          end
        end
      end
    end
  end

  int m_ivl_store = 0;

  task automatic emit();
    bit busy;
    busy = trc_valid && !(trc_ready && trc_eop);
    m_in = 0;
    if (busy) m_drop = 1;
    else begin
      expq[wr[7:0]] = {6'd0, 6'(m_ivl_store), 4'(m_bp), 4'(m_idle), 4'(m_beats),
                       5'd0, m_drop, 2'(m_kind)};
      wr++; m_drop = 0; lat_pend = 1;
    end
  endtask

  // stimulus
  task automatic cyc(input bit v, input bit r, input bit s, input bit e, input logic [15:0] d);
    sval = v; srdy = r; ssop = s; seop = e; sdata = d;
    @(posedge clk); #1;
  endtask

  task automatic send_pkt(input int nb, input logic [3:0] nib, input int idl,
                          input int bpc, input int gap);
    for (int i = 0; i < nb; i++) begin
      if (i > 0) begin
        for (int k = 0; k < idl; k++) cyc(0, 1, 0, 0, 16'h1234);
        for (int k = 0; k < bpc; k++) cyc(1, 0, 0, 0, 16'h5678);
      end
      cyc(1, 1, i == 0, i == nb - 1, (i == 0) ? {12'hA5C, nib} : 16'(i * 37 + 3));
    end
    for (int k = 0; k < gap; k++) cyc(0, 0, 0, 0, 16'h0);
  endtask

  task automatic drain();
    rdy_mode = 0;
    repeat (12) cyc(0, 0, 0, 0, 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(trc_valid == 0, "R11 reset valid", trc_valid, 0);
    @(posedge clk); #1;

    // R2 R7 basic video and control packets
    send_pkt(4, 4'h0, 0, 0, 6);
    send_pkt(3, 4'hF, 1, 0, 6);
    send_pkt(2, 4'h7, 0, 2, 6);

    // sweep: length, idle, backpressure, type, readiness (R2 R3 R4 R6 R7 R10)
    for (int t = 0; t < 3; t++)
      for (int nb = 1; nb <= 5; nb++)
        for (int id = 0; id <= 2; id++)
          for (int bp = 0; bp <= 2; bp++) begin
            rdy_mode = (t + nb) % 4 == 2 ? 1 : ((t + nb) % 4 == 3 ? 3 : 0);
            send_pkt(nb, (t == 0) ? 4'h0 : (t == 1) ? 4'hF : 4'h3, id, bp,
                     2 + ((nb + id + bp) % 5));
          end
    drain();

    // R5 saturation of counts and interval
    send_pkt(20, 4'h0, 1, 1, 70);
    send_pkt(1, 4'h0, 0, 0, 8);
    drain();

    // R10 overflow: port stalled, three short packets
    rdy_mode = 2;
    send_pkt(1, 4'hF, 0, 0, 1);
    send_pkt(1, 4'h0, 0, 0, 1);
    send_pkt(2, 4'h0, 0, 0, 1);
    drain();
    send_pkt(2, 4'h9, 0, 0, 8);
    drain();

    // R12 restart within an open window
    cyc(1, 1, 1, 0, 16'h000F);
    cyc(1, 1, 0, 0, 16'h0001);
    cyc(0, 1, 0, 0, 16'h0);
    send_pkt(3, 4'h0, 1, 1, 8);
    drain();

    // R1 stray traffic outside a window gives no record
    cyc(1, 1, 0, 0, 16'h0);
    cyc(1, 1, 0, 1, 16'h0);
    cyc(1, 0, 1, 1, 16'h0);
    cyc(0, 0, 0, 0, 16'h0);
    repeat (6) begin
      @(negedge clk);
      chk(trc_valid == 0, "R1 stray traffic ignored", trc_valid, 0);
    end
    @(posedge clk); #1;
    send_pkt(1, 4'hF, 0, 0, 8);
    drain();

    chk(rd == wr, "R10 all records delivered", wr - rd, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(0, "watchdog", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule